// File: doc/BRIEF.md
# Radix-16 Booth Signed Multiplier

This block multiplies a 19-bit two's complement data operand by a 19-bit two's complement coefficient and returns the exact 38-bit signed product. The coefficient is split into five radix-16 Booth digits in the range -8 to +8, so only five partial products are needed. A single shared stage forms the 1×, 3×, 5× and 7× multiples of the data operand. For each digit, a small selection unit picks one of those multiples, shifts it left by zero to three places, forces it to zero when the digit is zero, and inverts it when the digit is negative.

The five partial products and one correction word are reduced to a sum/carry pair by 3:2 carry-save compressors. A single carry-propagate adder then resolves the pair. The correction word supplies the +1 that completes each two's complement negation.

The result is captured in one output register together with a valid flag. A caller presents operands with `in_vld` high and reads `product` on the next cycle, when `out_vld` is high. The register keeps its value until another valid operand pair arrives.

Top module: `bm16_mult`

## Requirements
- R1: When `in_vld` is high at a rising clock edge, `product` after that edge equals the exact signed 38-bit value `x_in * c_in`.
- R2: `out_vld` is high in exactly the cycle that follows a cycle with `in_vld` high, and low after every cycle with `in_vld` low.
- R3: While `rst_n` is low, `product` is 0 and `out_vld` is 0. The reset is asynchronous and takes effect without waiting for a clock edge.
- R4: When `in_vld` is low at a clock edge, `product` keeps its previous value whatever `x_in` and `c_in` do.
- R5: The extreme operand pairs are exact: (-2^18)·(-2^18) = 2^36, (2^18-1)·(2^18-1) = 2^36-2^19+1, (-2^18)·(2^18-1) = -(2^36-2^18), and (-2^18)·(-1) = 2^18.
- R6: Each five-bit coefficient window is taken as bits [4j+3:4j-1], with bit -1 = 0 and the coefficient sign-extended above bit 18. A window of 00000 or 11111 yields a zero partial product. So C = 0 gives 0, and C = -1 gives -X.
- R7: Each digit magnitude is encoded as an odd-multiple select (00=1×, 01=3×, 10=5×, 11=7×) and a left shift of 0–3, as follows: 1→(00,0), 2→(00,1), 3→(01,0), 4→(00,2), 5→(10,0), 6→(01,1), 7→(11,0), 8→(00,3). Window bit 4 set marks a negative digit. Every coefficient from -8 to +8 gives d·X.
- R8: The shared pre-compute stage produces exactly 3X, 5X and 7X as 22-bit signed values.
- R9: A negative nonzero digit at position j contributes the inverted multiple shifted by 4j, plus a 1 at bit 4j of the correction word. The carry-save sum and carry add up, modulo 2^38, to the sum of all partial products and the correction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand pair valid; loads the product register |
| x_in | input | 19 | Data operand, two's complement |
| c_in | input | 19 | Coefficient operand, two's complement, Booth-recoded |
| out_vld | output | 1 | Product valid, one cycle after `in_vld` |
| product | output | 38 | Signed full-precision product |

## Verification
The odd multiples, partial products and carry-save pair are combinational, so they settle in the same cycle the operands are applied. The registered product and `out_vld` are due exactly one clock edge after `in_vld`. The bench therefore drives operands on the falling edge and samples the outputs on the next falling edge, half a period after the capturing rising edge. For hold checks, the bench changes the operands with `in_vld` low and samples after further edges. For the reset check, it samples while `rst_n` is low, with no edge in between.

// File: rtl/bm16_pkg.sv
package bm16_pkg;

  // Control word for one radix-16 Booth digit
  typedef struct packed {
    logic       neg;   // digit is negative: subtract the multiple
    logic       zero;  // digit magnitude is zero: gate the partial product
    logic [1:0] sel;   // odd multiple: 00=1x 01=3x 10=5x 11=7x
    logic [1:0] sf;    // left shift 0..3
  } bdig_t;

  // Value of a five-bit overlapping window as a Booth digit (-8..+8)
  function automatic int booth16_value(input logic [4:0] w);
    return -8 * int'(w[4]) + 4 * int'(w[3]) + 2 * int'(w[2]) + int'(w[1]) + int'(w[0]);
  endfunction

  // Split the magnitude into odd part and power of two
  function automatic bdig_t booth16_encode(input logic [4:0] w);
    bdig_t r;
    int    d;
    int    m;
    int    s;
    d = booth16_value(w);
    m = (d < 0) ? -d : d;
    s = 0;
    r.neg  = w[4];
    r.zero = (m == 0);
    for (int k = 0; k < 3; k++) begin
      if (m != 0 && (m % 2) == 0) begin
        m = m / 2;
        s = s + 1;
      end
    end
    r.sf  = 2'(s);
    r.sel = (m == 0) ? 2'b00 : 2'((m - 1) / 2);
    return r;
  endfunction

  // 3:2 compressor, sum word
  function automatic logic [63:0] csa_sum(input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] c);
    return a ^ b ^ c;
  endfunction

  // 3:2 compressor, carry word (not yet shifted)
  function automatic logic [63:0] csa_maj(input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/bm16_oddgen.sv
module bm16_oddgen #(
  parameter int WX = 19,
  localparam int MW = WX + 3
) (
  input  logic signed [WX-1:0] x,
  output logic signed [MW-1:0] m1,
  output logic signed [MW-1:0] m3,
  output logic signed [MW-1:0] m5,
  output logic signed [MW-1:0] m7
);

  logic signed [MW-1:0] xe;

  assign xe = {{3{x[WX-1]}}, x};

  // One carry-propagate adder per odd multiple; shared by all digit units
  assign m1 = xe;
  assign m3 = (xe <<< 1) + xe;
  assign m5 = (xe <<< 2) + xe;
  assign m7 = (xe <<< 3) - xe;

endmodule

// File: rtl/bm16_ppunit.sv
module bm16_ppunit
  import bm16_pkg::*;
#(
  parameter int WX  = 19,
  parameter int PW  = 38,
  parameter int POS = 0,
  localparam int MW  = WX + 3,
  localparam int SHW = MW + 3
) (
  input  logic signed [MW-1:0] m1,
  input  logic signed [MW-1:0] m3,
  input  logic signed [MW-1:0] m5,
  input  logic signed [MW-1:0] m7,
  input  logic [4:0]           win,
  output logic [PW-1:0]        pp,
  output logic                 neg_o,
  output logic                 zero_o,
  output logic                 corr_o
);

  bdig_t                 enc;
  logic signed [MW-1:0]  pick;
  logic signed [SHW-1:0] shifted;
  logic [PW-1:0]         wide;
  logic [PW-1:0]         signed_w;

  assign enc = booth16_encode(win);

  // 4:1 odd-multiple select
  always_comb begin
    unique case (enc.sel)
      2'b00:   pick = m1;
      2'b01:   pick = m3;
      2'b10:   pick = m5;
      default: pick = m7;
    endcase
  end

  // 0..3 bit shifter
  assign shifted = {{3{pick[MW-1]}}, pick} <<< enc.sf;

  // Sign-extend to full product width
  assign wide = {{(PW-SHW){shifted[SHW-1]}}, shifted};

  // Conditional inversion; +1 is supplied separately at weight POS
  assign signed_w = (enc.neg && !enc.zero) ? ~wide : wide;

  // Zero gating and placement at digit weight
  assign pp     = enc.zero ? '0 : (signed_w << POS);
  assign neg_o  = enc.neg;
  assign zero_o = enc.zero;
  assign corr_o = enc.neg && !enc.zero;

endmodule

// File: rtl/bm16_csa_array.sv
module bm16_csa_array
  import bm16_pkg::*;
#(
  parameter int PW  = 38,
  parameter int NOP = 6
) (
  input  logic [NOP-1:0][PW-1:0] ops,
  output logic [PW-1:0]          sum_o,
  output logic [PW-1:0]          carry_o
);

  logic [NOP-1:0][PW-1:0] s_acc;
  logic [NOP-1:0][PW-1:0] c_acc;

  assign s_acc[0] = '0;
  assign c_acc[0] = '0;
  assign s_acc[1] = ops[0];
  assign c_acc[1] = ops[1];

  // Each level folds one more operand into the redundant pair
  for (genvar k = 2; k < NOP; k++) begin : g_lvl
    logic [63:0] sw;
    logic [63:0] mw;
    assign sw = csa_sum(64'(s_acc[k-1]), 64'(c_acc[k-1]), 64'(ops[k]));
    assign mw = csa_maj(64'(s_acc[k-1]), 64'(c_acc[k-1]), 64'(ops[k]));
    assign s_acc[k] = sw[PW-1:0];
    assign c_acc[k] = {mw[PW-2:0], 1'b0};
  end

  assign sum_o   = s_acc[NOP-1];
  assign carry_o = c_acc[NOP-1];

endmodule

// File: rtl/bm16_mult.sv
module bm16_mult #(
  parameter int WX = 19,
  parameter int WC = 19,
  localparam int PW   = WX + WC,
  localparam int MW   = WX + 3,
  localparam int NDIG = (WC + 3) / 4,
  localparam int CEW  = 4 * NDIG + 1,
  localparam int NOP  = NDIG + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [WX-1:0] x_in,
  input  logic signed [WC-1:0] c_in,
  output logic                 out_vld,
  output logic signed [PW-1:0] product
);

  logic signed [MW-1:0]   odd1;
  logic signed [MW-1:0]   odd3;
  logic signed [MW-1:0]   odd5;
  logic signed [MW-1:0]   odd7;
  logic [CEW-1:0]         cext;
  logic [NDIG-1:0][4:0]   win;
  logic [NDIG-1:0][PW-1:0] pp;
  logic [NDIG-1:0]        dneg;
  logic [NDIG-1:0]        dzero;
  logic [NDIG-1:0]        dcorr;
  logic [PW-1:0]          corr_vec;
  logic [NOP-1:0][PW-1:0] ops;
  logic [PW-1:0]          cs_sum;
  logic [PW-1:0]          cs_carry;
  logic [PW-1:0]          resolved;

  bm16_oddgen #(.WX(WX)) u_odd (
    .x  (x_in),
    .m1 (odd1),
    .m3 (odd3),
    .m5 (odd5),
    .m7 (odd7)
  );

  // Coefficient with implicit zero below bit 0 and sign extension on top
  assign cext = {{(CEW-WC-1){c_in[WC-1]}}, c_in, 1'b0};

  for (genvar j = 0; j < NDIG; j++) begin : g_dig
    assign win[j] = cext[4*j+4 : 4*j];

    bm16_ppunit #(.WX(WX), .PW(PW), .POS(4*j)) u_pp (
      .m1     (odd1),
      .m3     (odd3),
      .m5     (odd5),
      .m7     (odd7),
      .win    (win[j]),
      .pp     (pp[j]),
      .neg_o  (dneg[j]),
      .zero_o (dzero[j]),
      .corr_o (dcorr[j])
    );

    assign ops[j] = pp[j];
  end

  // Negation carries at each digit weight
  always_comb begin
    corr_vec = '0;
    for (int j = 0; j < NDIG; j++) corr_vec[4*j] = dcorr[j];
  end

  assign ops[NDIG] = corr_vec;

  bm16_csa_array #(.PW(PW), .NOP(NOP)) u_csa (
    .ops     (ops),
    .sum_o   (cs_sum),
    .carry_o (cs_carry)
  );

  assign resolved = cs_sum + cs_carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) product <= resolved;
    end
  end

endmodule

// File: rtl/bm16_mult_chk.sv
module bm16_mult_chk #(
  parameter int WX = 19,
  parameter int WC = 19,
  localparam int PW   = WX + WC,
  localparam int MW   = WX + 3,
  localparam int NDIG = (WC + 3) / 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_vld,
  input logic signed [WX-1:0]    x_in,
  input logic signed [WC-1:0]    c_in,
  input logic                    out_vld,
  input logic signed [PW-1:0]    product,
  input logic signed [MW-1:0]    odd3,
  input logic signed [MW-1:0]    odd5,
  input logic signed [MW-1:0]    odd7,
  input logic [NDIG-1:0][4:0]    win,
  input logic [NDIG-1:0][PW-1:0] pp,
  input logic [PW-1:0]           corr_vec,
  input logic [PW-1:0]           cs_sum,
  input logic [PW-1:0]           cs_carry
);

  logic [PW-1:0]        pp_total;
  logic signed [MW-1:0] xe;

  always_comb begin
    pp_total = corr_vec;
    for (int j = 0; j < NDIG; j++) pp_total = pp_total + pp[j];
  end

  assign xe = MW'(x_in);

  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> product == $past(x_in) * $past(c_in)); // R1

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld); // R2

  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(product)); // R4

  AST_ODD_MULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (odd3 == xe * 3) && (odd5 == xe * 5) && (odd7 == xe * 7)); // R8

  AST_CSA_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(cs_sum + cs_carry) == pp_total); // R9

  for (genvar j = 0; j < NDIG; j++) begin : g_zw
    AST_ZERO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (win[j] == 5'b00000 || win[j] == 5'b11111) |-> pp[j] == '0); // R6
  end

endmodule

bind bm16_mult bm16_mult_chk #(.WX(WX), .WC(WC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .x_in     (x_in),
  .c_in     (c_in),
  .out_vld  (out_vld),
  .product  (product),
  .odd3     (odd3),
  .odd5     (odd5),
  .odd7     (odd7),
  .win      (win),
  .pp       (pp),
  .corr_vec (corr_vec),
  .cs_sum   (cs_sum),
  .cs_carry (cs_carry)
);

// File: tb/sim_bm16_mult.sv
`timescale 1ns/1ps
module sim_bm16_mult;

  localparam int NV = 14;

  localparam longint TX [NV] = '{
    0, 1, -1, 262143, -262144, -262144, 262143, -262144,
    7, 1000, -3, 12345, 256, 4096
  };
  localparam longint TC [NV] = '{
    0, 1, -1, 1, 1, -262144, 262143, 262143,
    8, -8, 15, -1, 256, -4096
  };
  localparam longint TP [NV] = '{
    0, 1, 1, 262143, -262144, 64'sd68719476736, 64'sd68718952449, -64'sd68719214592,
    56, -8000, -45, -12345, 65536, -16777216
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_vld = 1'b0;
  logic signed [18:0] x_in = '0;
  logic signed [18:0] c_in = '0;
  logic               out_vld;
  logic signed [37:0] product;

  int nchk  = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  bm16_mult u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .x_in    (x_in),
    .c_in    (c_in),
    .out_vld (out_vld),
    .product (product)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at falling edge, sample one falling edge later
  task automatic apply(input string req, input longint xv, input longint cv, input longint exp);
    @(negedge clk);
    x_in   = 19'(xv);
    c_in   = 19'(cv);
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    check(req, longint'(product), exp);
    check("R2 out_vld after in_vld", longint'(out_vld), 1);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    longint held;
    // R3: reset state
    #7;
    check("R3 product in reset", longint'(product), 0);
    check("R3 out_vld in reset", longint'(out_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 out_vld idle", longint'(out_vld), 0);

    // R1/R5: table walk
    for (int i = 0; i < NV; i++) apply("R1 R5 table", TX[i], TC[i], TP[i]);

    // R5: more extremes
    apply("R5 min times -1", -262144, -1, 262144);
    apply("R5 max times min", 262143, -262144, -64'sd68719214592);

    // R6: all-zero and all-one windows
    apply("R6 C=0", -123456, 0, 0);
    apply("R6 C=-1", -123456, -1, 123456);
    apply("R6 C=-1 max X", 262143, -1, -262143);

    // R7: every digit value in the lowest window
    for (int d = -8; d <= 8; d++) apply("R7 digit sweep", -77777, d, -77777 * longint'(d));
    // R7: digit in upper windows (C = d * 16^3)
    for (int d = -8; d <= 7; d++) apply("R7 upper digit", 191919, d * 4096, 191919 * longint'(d) * 4096);

    // R8/R9: multiples of 3,5,7 with negative digits
    apply("R8 R9 odd negatives", 99999, -7 - 16 * 5 - 256 * 3, 99999 * longint'(-7 - 80 - 768));

    // R4: hold while in_vld low
    held = longint'(product);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      x_in = 19'($urandom);
      c_in = 19'($urandom);
      @(negedge clk);
      check("R4 hold product", longint'(product), held);
      check("R2 out_vld low", longint'(out_vld), 0);
    end

    // R1: random operands
    for (int k = 0; k < 300; k++) begin
      logic signed [18:0] rx;
      logic signed [18:0] rc;
      rx = 19'($urandom);
      rc = 19'($urandom);
      apply("R1 random", longint'(rx), longint'(rc), longint'(rx) * longint'(rc));
    end

    // Back-to-back valid operands
    @(negedge clk);
    x_in = 19'(-5); c_in = 19'(9); in_vld = 1'b1;
    @(negedge clk);
    check("R1 back-to-back first", longint'(product), -45);
    x_in = 19'(1234); c_in = 19'(-4321);
    @(negedge clk);
    in_vld = 1'b0;
    check("R1 back-to-back second", longint'(product), -64'sd5332114);
    check("R2 back-to-back valid", longint'(out_vld), 1);

    // R3: asynchronous reset mid-run
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R3 async clear product", longint'(product), 0);
    check("R3 async clear out_vld", longint'(out_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule